// File: doc/BRIEF.md
# Per-Channel PWM Error Recovery Sequencer

This block sits between a multi-channel PWM modulator and the output stages. For every channel it takes the modulator's P and M streams together with an active-low recovery bit. It produces gated copies of those streams and a per-channel valid flag that tells the power stage whether the channel is being driven. Pulling a channel's recovery bit low takes that channel out of service. After a short delay, valid drops and both drive lines are held low. Returning the bit high starts a long hold-off. When the hold-off ends, the channel comes back in two steps aligned to PWM frame boundaries: first valid rises, and one frame later the drive lines are released. This keeps entry and exit quiet.

One shared select input picks the entry delay, short or long. Its value is taken at the moment a channel starts recovery. The channels are fully independent. All delays are counted in system clock cycles and set by parameters: the defaults give 6 µs, 47 µs and a 4.5 ms hold-off at 100 MHz. An internal free-running counter marks the PWM frame boundaries.

Top module: `pwm_recovery_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, every valid flag and every P/M output is low. A channel leaves this state only through the hold-off of R7, which starts at the first edge after reset with its bit high.
- R2: A channel in normal operation drives valid high and copies its P and M inputs to its outputs with one clock cycle of latency.
- R3: Whenever a channel's valid flag is low, its P and M outputs are low.
- R4: Suppose a running channel's recovery bit is sampled low. Its valid flag falls exactly SHORT_CYC cycles after that first edge when the select input is 0, and LONG_CYC cycles after it when the select is 1. P and M go low on that same cycle, and until then they keep passing the inputs.
- R5: The delay choice is captured at the first edge that samples the bit low. Changing the select during the delay has no effect on it.
- R6: Once entry has begun, it completes even if the bit returns high during the delay. Valid still falls at the R4 time, and the channel then recovers normally.
- R7: After the bit is sampled high while the channel is held, valid rises between HOLDOFF_CYC+1 and HOLDOFF_CYC+FRAME_CYC cycles after that first edge. Valid rises only on a cycle where the bit was high.
- R8: After valid rises, P and M stay low for exactly FRAME_CYC cycles. Then they are released to follow the inputs.
- R9: If the bit is sampled low during the hold-off, or while valid is high but the outputs are not yet released, the channel returns at the next edge to the held state with valid low. This happens with no entry delay, and the hold-off restarts from the next rise of the bit.
- R10: Recovery on one channel leaves the valid flag and P/M outputs of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_n_i | input | NUM_CH | Active-low recovery bit per channel |
| dly_sel_i | input | 1 | Entry delay select: 0 short, 1 long |
| pwm_p_i | input | NUM_CH | P streams from the modulator |
| pwm_m_i | input | NUM_CH | M streams from the modulator |
| pwm_p_o | output | NUM_CH | Gated P streams |
| pwm_m_o | output | NUM_CH | Gated M streams |
| valid_o | output | NUM_CH | Per-channel valid flag |

## Verification
The bench builds the block with six channels, SHORT_CYC=3, LONG_CYC=9, HOLDOFF_CYC=50 and FRAME_CYC=8. At these values the multi-millisecond hold-off becomes a few dozen cycles. Every entry and exit, including re-entry during the hold-off and during the frame before release, then fits in a short run. The 3-versus-9 split makes the two entry delays easy to tell apart, so a latched or swapped select shows up as a wrong count. An 8-cycle frame keeps the exit window narrow enough to bound the hold-off tightly.

// File: rtl/pwm_recovery_pkg.sv
package pwm_recovery_pkg;

  typedef enum logic [2:0] {
    CH_RUN   = 3'd0,  // normal modulation
    CH_ENTER = 3'd1,  // entry delay counting, still driving
    CH_HALT  = 3'd2,  // held low, bit low
    CH_HOLD  = 3'd3,  // bit high, hold-off counting
    CH_SYNC  = 3'd4,  // hold-off done, waiting for frame boundary
    CH_ARM   = 3'd5   // valid high, drive still gated until next boundary
  } ch_state_t;

  function automatic logic st_valid(input ch_state_t s);
    return (s == CH_RUN) || (s == CH_ENTER) || (s == CH_ARM);
  endfunction

  function automatic logic st_drive(input ch_state_t s);
    return (s == CH_RUN) || (s == CH_ENTER);
  endfunction

endpackage

// File: rtl/pwm_frame_tick.sv
module pwm_frame_tick #(
  parameter int FRAME_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int FW = (FRAME_CYC > 1) ? $clog2(FRAME_CYC) : 1;
  localparam logic [FW-1:0] LAST = FW'(FRAME_CYC - 1);

  logic [FW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/pwm_recovery_chan.sv
module pwm_recovery_chan
  import pwm_recovery_pkg::*;
#(
  parameter int SHORT_CYC   = 600,
  parameter int LONG_CYC    = 4700,
  parameter int HOLDOFF_CYC = 450000
) (
  input  logic clk,
  input  logic rst,
  input  logic rec_n_i,
  input  logic dly_sel_i,
  input  logic frame_tick_i,
  input  logic p_i,
  input  logic m_i,
  output logic p_o,
  output logic m_o,
  output logic valid_o
);
  localparam int MAXC = (HOLDOFF_CYC > LONG_CYC) ?
                        ((HOLDOFF_CYC > SHORT_CYC) ? HOLDOFF_CYC : SHORT_CYC) :
                        ((LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLDOFF_CYC - 1);

  ch_state_t     st_q, st_nxt;
  logic [CW-1:0] cnt_q;
  logic          long_q;
  logic [CW-1:0] enter_last;

  assign enter_last = long_q ? LONG_LAST : SHORT_LAST;

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      CH_RUN:   if (!rec_n_i) st_nxt = CH_ENTER;
      CH_ENTER: if (cnt_q == enter_last) st_nxt = CH_HALT;
      CH_HALT:  if (rec_n_i) st_nxt = CH_HOLD;
      CH_HOLD: begin
        if (!rec_n_i)                st_nxt = CH_HALT;
        else if (cnt_q == HOLD_LAST) st_nxt = CH_SYNC;
      end
      CH_SYNC: begin
        if (!rec_n_i)          st_nxt = CH_HALT;
        else if (frame_tick_i) st_nxt = CH_ARM;
      end
      CH_ARM: begin
        if (!rec_n_i)          st_nxt = CH_HALT;
        else if (frame_tick_i) st_nxt = CH_RUN;
      end
      default: st_nxt = CH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= CH_HALT;
      cnt_q   <= '0;
      long_q  <= 1'b0;
      valid_o <= 1'b0;
      p_o     <= 1'b0;
      m_o     <= 1'b0;
    end else begin
      st_q <= st_nxt;
      if (st_nxt != st_q) begin
        cnt_q <= '0;
      end else if (st_q == CH_ENTER || st_q == CH_HOLD) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (st_q == CH_RUN && !rec_n_i) begin
        long_q <= dly_sel_i;
      end
      valid_o <= st_valid(st_nxt);
      p_o     <= st_drive(st_nxt) & p_i;
      m_o     <= st_drive(st_nxt) & m_i;
    end
  end
endmodule

// File: rtl/pwm_recovery_seq.sv
module pwm_recovery_seq #(
  parameter int NUM_CH      = 6,
  parameter int SHORT_CYC   = 600,
  parameter int LONG_CYC    = 4700,
  parameter int HOLDOFF_CYC = 450000,
  parameter int FRAME_CYC   = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] rec_n_i,
  input  logic              dly_sel_i,
  input  logic [NUM_CH-1:0] pwm_p_i,
  input  logic [NUM_CH-1:0] pwm_m_i,
  output logic [NUM_CH-1:0] pwm_p_o,
  output logic [NUM_CH-1:0] pwm_m_o,
  output logic [NUM_CH-1:0] valid_o
);
  logic frame_tick;

  pwm_frame_tick #(.FRAME_CYC(FRAME_CYC)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .tick_o (frame_tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_recovery_chan #(
      .SHORT_CYC   (SHORT_CYC),
      .LONG_CYC    (LONG_CYC),
      .HOLDOFF_CYC (HOLDOFF_CYC)
    ) u_chan (
      .clk          (clk),
      .rst          (rst),
      .rec_n_i      (rec_n_i[g]),
      .dly_sel_i    (dly_sel_i),
      .frame_tick_i (frame_tick),
      .p_i          (pwm_p_i[g]),
      .m_i          (pwm_m_i[g]),
      .p_o          (pwm_p_o[g]),
      .m_o          (pwm_m_o[g]),
      .valid_o      (valid_o[g])
    );
  end
endmodule

// File: rtl/pwm_recovery_seq_chk.sv
module pwm_recovery_seq_chk #(
  parameter int NUM_CH = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] rec_n_i,
  input logic [NUM_CH-1:0] pwm_p_o,
  input logic [NUM_CH-1:0] pwm_m_o,
  input logic [NUM_CH-1:0] valid_o
);
  // R1: outputs cleared by reset
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (valid_o == '0) && (pwm_p_o == '0) && (pwm_m_o == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R3: no drive while valid is low
    a_r3_gated_when_invalid: assert property (@(posedge clk) disable iff (rst)
      !valid_o[g] |-> (!pwm_p_o[g] && !pwm_m_o[g]));

    // R7: valid only rises when the bit was high
    a_r7_rise_needs_bit: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_o[g]) |-> $past(rec_n_i[g]));

    // R8: drive is released only after valid was already high
    a_r8_valid_leads_drive: assert property (@(posedge clk) disable iff (rst)
      ($rose(pwm_p_o[g]) || $rose(pwm_m_o[g])) |-> $past(valid_o[g]));

    // R9: a held channel with its bit low stays held
    a_r9_stay_held: assert property (@(posedge clk) disable iff (rst)
      (!valid_o[g] && !rec_n_i[g]) |=> !valid_o[g]);
  end
endmodule

bind pwm_recovery_seq pwm_recovery_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rec_n_i (rec_n_i),
  .pwm_p_o (pwm_p_o),
  .pwm_m_o (pwm_m_o),
  .valid_o (valid_o)
);

// File: tb/test_pwm_recovery_seq.sv
module test_pwm_recovery_seq;
  localparam int NCH   = 6;
  localparam int SHORT = 3;
  localparam int LONG  = 9;
  localparam int HOLD  = 50;
  localparam int FRAME = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] rec_n = '1;
  logic           sel = 1'b0;
  logic [NCH-1:0] p_i = '0;
  logic [NCH-1:0] m_i = '0;
  logic [NCH-1:0] p_o, m_o, valid;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pwm_recovery_seq #(
    .NUM_CH(NCH), .SHORT_CYC(SHORT), .LONG_CYC(LONG),
    .HOLDOFF_CYC(HOLD), .FRAME_CYC(FRAME)
  ) i_pwm_recovery_seq (
    .clk(clk), .rst(rst), .rec_n_i(rec_n), .dly_sel_i(sel),
    .pwm_p_i(p_i), .pwm_m_i(m_i),
    .pwm_p_o(p_o), .pwm_m_o(m_o), .valid_o(valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive bit low, count negedges until valid low
  task automatic enter(input int ch, input bit s, input int exp_d, input string req);
    int n = 0;
    rec_n[ch] = 1'b0;
    sel = s;
    p_i = '1; m_i = '1;
    while (valid[ch] && n < 200) begin
      @(negedge clk);
      n++;
      if (n == exp_d) check(p_o[ch] && m_o[ch], {req, " drive during delay"}, int'(p_o[ch]), 1);
    end
    check(n - 1 == exp_d, {req, " entry delay"}, n - 1, exp_d);
    check(!p_o[ch] && !m_o[ch], {req, " R4 drive low with valid"}, int'(p_o[ch]), 0);
  endtask

  // raise bit, check hold-off window and frame-gated release
  task automatic leave(input int ch, input string req);
    int n = 0;
    int m = 0;
    rec_n[ch] = 1'b1;
    p_i = '1; m_i = '1;
    while (!valid[ch] && n < HOLD + FRAME + 50) begin
      @(negedge clk);
      n++;
      if (!valid[ch]) check(!p_o[ch], {req, " R3 gated while held"}, int'(p_o[ch]), 0);
    end
    check((n - 1 >= HOLD + 1) && (n - 1 <= HOLD + FRAME), {req, " R7 hold-off window"}, n - 1, HOLD + 1);
    while (!p_o[ch] && m < 4 * FRAME) begin
      @(negedge clk);
      m++;
    end
    check(m == FRAME, {req, " R8 release after valid"}, m, FRAME);
    check(valid[ch] && m_o[ch], {req, " R8 released state"}, int'(m_o[ch]), 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    rec_n = '1;
    p_i = '1; m_i = '1;
    repeat (3) @(negedge clk);
    check(valid == '0, "R1 valid in reset", int'(valid), 0);
    check(p_o == '0 && m_o == '0, "R1 drive in reset", int'(p_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(valid == '0 && p_o == '0, "R1 first cycle after reset", int'(valid), 0);
    leave(0, "R1");
    check(valid == '1, "R1 all channels back", int'(valid), 63);
  endtask

  task automatic t_pass();
    logic [NCH-1:0] pat [4] = '{6'h2A, 6'h15, 6'h3F, 6'h09};
    for (int i = 0; i < 4; i++) begin
      p_i = pat[i];
      m_i = ~pat[i];
      @(negedge clk);
      check(p_o == pat[i] && m_o == ~pat[i] && valid == '1, "R2 pass-through", int'(p_o), int'(pat[i]));
    end
  endtask

  task automatic t_entry_short();
    enter(1, 1'b0, SHORT, "R4 short");
    leave(1, "R4 short exit");
  endtask

  task automatic t_entry_long();
    enter(2, 1'b1, LONG, "R4 long");
    leave(2, "R4 long exit");
  endtask

  task automatic t_sel_latch();
    int n = 0;
    rec_n[3] = 1'b0;
    sel = 1'b0;
    @(negedge clk);
    n = 1;
    sel = 1'b1;
    while (valid[3] && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n - 1 == SHORT, "R5 select latched at entry", n - 1, SHORT);
    sel = 1'b0;
    leave(3, "R5 exit");
  endtask

  task automatic t_commit();
    int n = 0;
    rec_n[4] = 1'b0;
    sel = 1'b1;
    @(negedge clk);
    n = 1;
    rec_n[4] = 1'b1;
    while (valid[4] && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(n - 1 == LONG, "R6 entry completes", n - 1, LONG);
    n = 0;
    while (!valid[4] && n < HOLD + FRAME + 50) begin
      @(negedge clk);
      n++;
    end
    check(valid[4], "R6 recovers", int'(valid[4]), 1);
    repeat (FRAME + 1) @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic t_reenter();
    enter(5, 1'b0, SHORT, "R9 setup");
    rec_n[5] = 1'b1;
    repeat (20) @(negedge clk);
    rec_n[5] = 1'b0;
    repeat (3) @(negedge clk);
    check(!valid[5] && !p_o[5], "R9 drop during hold-off", int'(valid[5]), 0);
    leave(5, "R9 restarted hold-off");
    // drop during the gated frame after valid rises
    enter(5, 1'b0, SHORT, "R9 setup2");
    rec_n[5] = 1'b1;
    while (!valid[5]) @(negedge clk);
    rec_n[5] = 1'b0;
    @(negedge clk);
    check(!valid[5] && !p_o[5], "R9 drop before release", int'(valid[5]), 0);
    leave(5, "R9 second exit");
  endtask

  task automatic t_indep();
    logic [NCH-1:0] mask = 6'b111011;
    rec_n[2] = 1'b0;
    sel = 1'b0;
    for (int i = 0; i < SHORT + 6; i++) begin
      p_i = 6'(i * 5);
      m_i = ~6'(i * 5);
      @(negedge clk);
      check((valid & mask) == mask, "R10 others valid", int'(valid), int'(mask));
      check((p_o & mask) == (6'(i * 5) & mask), "R10 others pass", int'(p_o & mask), int'(6'(i * 5) & mask));
    end
    leave(2, "R10 exit");
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_entry_short();
    t_entry_long();
    t_sel_latch();
    t_commit();
    t_reenter();
    t_indep();
    t_pass();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule